// File: doc/BRIEF.md
# Draw Vertex Index Sequencer

This block turns a draw trigger into the ordered list of vertex numbers that the draw covers. It holds a small set of configuration registers that a command processor writes over a word-wide write port. When a trigger register is written, the block copies the configuration it needs and then emits one vertex number per accepted transfer on a valid/ready stream. A one-cycle done pulse marks the end of the draw.

A linear draw needs no memory traffic: each number is the loop position plus a first-vertex offset. An indexed draw reads each number from an index array in memory through a byte-wide read port with one cycle of latency. The elements are either one byte or two bytes wide, and two-byte elements are assembled from two reads. The busy output stays high for the whole draw, and a trigger that arrives while it is high is dropped.

Top module: `vis_sequencer`

## Requirements
- R1: Configuration registers: 0x200 holds the array base in units of 8 bytes in bits 28:0. 0x227 holds the index descriptor, where bits 30:0 are a byte offset from the base and bit 31 selects the element width (0 = one byte, 1 = two bytes). 0x228 holds the vertex count and 0x22A holds the first-vertex offset. A draw uses the values present when its trigger is accepted. Later register writes affect only later draws.
- R2: A write to 0x22E starts a linear draw. It emits the first-vertex offset plus i for i = 0 up to count-1, in ascending order, modulo 2^32.
- R3: A write to 0x22F starts an indexed draw. With one-byte elements, number i is the byte at address base*8 + offset + i, zero-extended. The first-vertex offset register has no effect on this draw.
- R4: With two-byte elements, number i is read little-endian: the low byte is at base*8 + offset + 2i and the high byte at the next address.
- R5: Exactly count numbers are emitted, one per cycle with vtx_valid and vtx_ready both high. While vtx_valid is high and vtx_ready is low, vtx_num holds its value.
- R6: busy goes high in the cycle after an accepted trigger with a non-zero count. It falls in the cycle after the final transfer, and draw_done is high for exactly that one cycle.
- R7: A trigger with a count of zero raises draw_done in the next cycle. In that case busy stays low and nothing is emitted.
- R8: A trigger written while busy is high is ignored. The running draw continues unchanged and no extra draw follows.
- R9: After reset, busy, vtx_valid, draw_done and mem_rd_en are low.
- R10: mem_rd_en is high only during an indexed draw. The memory returns the addressed byte on mem_rd_data in the cycle after mem_rd_en.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_wr_addr | input | 10 | Register word address |
| cfg_wr_data | input | 32 | Register write data |
| mem_rd_en | output | 1 | Index byte read request |
| mem_rd_addr | output | 32 | Byte address of the read |
| mem_rd_data | input | 8 | Read data, one cycle after the request |
| vtx_valid | output | 1 | Vertex number available |
| vtx_ready | input | 1 | Consumer accepts the vertex number |
| vtx_num | output | 32 | Vertex number |
| draw_done | output | 1 | One-cycle end-of-draw pulse |
| busy | output | 1 | Draw in progress |

## Verification
The bound checker checks the stream and control rules on every cycle. It checks that vtx_num holds while it is stalled, that valid and memory reads appear only while busy, that busy starts only after a trigger write, that the fall of busy coincides with draw_done, and that a trigger written mid-draw cannot end the draw. The correctness of the numbers themselves can only be shown by the bench scenarios. These cover linear values with wrap-around, one-byte and two-byte elements taken from the right addresses, the first-vertex offset having no effect on indexed draws, zero-count draws, and configuration snapshots taken under stalls and dropped triggers.

// File: rtl/vis_pkg.sv
`timescale 1ns/1ps
package vis_pkg;
  localparam int REG_AW = 10;
  localparam logic [REG_AW-1:0] ADR_BASE  = 10'h200;
  localparam logic [REG_AW-1:0] ADR_DESC  = 10'h227;
  localparam logic [REG_AW-1:0] ADR_COUNT = 10'h228;
  localparam logic [REG_AW-1:0] ADR_FIRST = 10'h22A;
  localparam logic [REG_AW-1:0] ADR_GO_LIN = 10'h22E;
  localparam logic [REG_AW-1:0] ADR_GO_IDX = 10'h22F;
  localparam int BASE_W = 29;
  localparam int BASE_SHIFT = 3;
  localparam int DESC_OFF_W = 31;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_RDLO  = 3'd1,
    ST_GOTLO = 3'd2,
    ST_GOTHI = 3'd3,
    ST_EMIT  = 3'd4
  } seq_state_t;
endpackage

// File: rtl/vis_cfg_regs.sv
`timescale 1ns/1ps
module vis_cfg_regs
  import vis_pkg::*;
#(
  parameter int VTX_W = 32,
  parameter int CNT_W = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [REG_AW-1:0]     wr_addr,
  input  logic [31:0]           wr_data,
  output logic [BASE_W-1:0]     base_q,
  output logic [31:0]           desc_q,
  output logic [CNT_W-1:0]      count_q,
  output logic [VTX_W-1:0]      first_q,
  output logic                  go_lin,
  output logic                  go_idx
);
  logic en_base, en_desc, en_count, en_first;

  always_comb begin
    en_base  = wr_en && (wr_addr == ADR_BASE);
    en_desc  = wr_en && (wr_addr == ADR_DESC);
    en_count = wr_en && (wr_addr == ADR_COUNT);
    en_first = wr_en && (wr_addr == ADR_FIRST);
    go_lin   = wr_en && (wr_addr == ADR_GO_LIN);
    go_idx   = wr_en && (wr_addr == ADR_GO_IDX);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q  <= '0;
      desc_q  <= '0;
      count_q <= '0;
      first_q <= '0;
    end else begin
      if (en_base)  base_q  <= wr_data[BASE_W-1:0];
      if (en_desc)  desc_q  <= wr_data;
      if (en_count) count_q <= wr_data[CNT_W-1:0];
      if (en_first) first_q <= wr_data[VTX_W-1:0];
    end
  end
endmodule

// File: rtl/vis_addr_gen.sv
`timescale 1ns/1ps
module vis_addr_gen
  import vis_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load,
  input  logic                  step,
  input  logic                  wide,
  input  logic                  hi_sel,
  input  logic [BASE_W-1:0]     base,
  input  logic [DESC_OFF_W-1:0] offset,
  output logic [ADDR_W-1:0]     rd_addr
);
  localparam int BYTE_BASE_W = BASE_W + BASE_SHIFT;

  logic [ADDR_W-1:0] ptr_q, ptr_d;
  logic              ptr_en;
  logic [ADDR_W-1:0] start_addr;
  logic [ADDR_W-1:0] stride;

  always_comb begin
    start_addr = ADDR_W'({base, {BASE_SHIFT{1'b0}}}) + ADDR_W'(offset);
    stride     = wide ? ADDR_W'(2) : ADDR_W'(1);
    ptr_en     = load || step;
    ptr_d      = load ? start_addr : (ptr_q + stride);
    rd_addr    = ptr_q + ADDR_W'(hi_sel);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else if (ptr_en) ptr_q <= ptr_d;
  end

  if (BYTE_BASE_W > ADDR_W) begin : g_narrow
    // base bits above ADDR_W wrap away; address arithmetic is modulo 2^ADDR_W
  end
endmodule

// File: rtl/vis_seq_ctrl.sv
`timescale 1ns/1ps
module vis_seq_ctrl
  import vis_pkg::*;
#(
  parameter int VTX_W = 32,
  parameter int CNT_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go_lin,
  input  logic              go_idx,
  input  logic [CNT_W-1:0]  cfg_count,
  input  logic [VTX_W-1:0]  cfg_first,
  input  logic              cfg_wide,
  input  logic [7:0]        rd_data,
  input  logic              vtx_ready,
  output logic              ptr_load,
  output logic              ptr_step,
  output logic              hi_sel,
  output logic              wide_q,
  output logic              rd_en,
  output logic              vtx_valid,
  output logic [VTX_W-1:0]  vtx_num,
  output logic              done,
  output logic              busy
);
  seq_state_t         st_q, st_d;
  logic [CNT_W-1:0]   rem_q, rem_d;
  logic [VTX_W-1:0]   num_q, num_d;
  logic [7:0]         lo_q, lo_d;
  logic               idx_q, idx_d;
  logic               wide_d;
  logic               done_q, done_d;
  logic               xfer, last;

  always_comb begin
    st_d     = st_q;
    rem_d    = rem_q;
    num_d    = num_q;
    lo_d     = lo_q;
    idx_d    = idx_q;
    wide_d   = wide_q;
    done_d   = 1'b0;
    ptr_load = 1'b0;
    ptr_step = 1'b0;
    hi_sel   = 1'b0;
    rd_en    = 1'b0;
    xfer     = (st_q == ST_EMIT) && vtx_ready;
    last     = (rem_q == CNT_W'(1));
    unique case (st_q)
      ST_IDLE: begin
        if (go_lin || go_idx) begin
          if (cfg_count == '0) begin
            done_d = 1'b1;
          end else begin
            rem_d  = cfg_count;
            idx_d  = go_idx;
            wide_d = cfg_wide;
            if (go_idx) begin
              ptr_load = 1'b1;
              st_d     = ST_RDLO;
            end else begin
              num_d = cfg_first;
              st_d  = ST_EMIT;
            end
          end
        end
      end
      ST_RDLO: begin
        rd_en = 1'b1;
        st_d  = ST_GOTLO;
      end
      ST_GOTLO: begin
        if (wide_q) begin
          lo_d   = rd_data;
          rd_en  = 1'b1;
          hi_sel = 1'b1;
          st_d   = ST_GOTHI;
        end else begin
          num_d = VTX_W'(rd_data);
          st_d  = ST_EMIT;
        end
      end
      ST_GOTHI: begin
        num_d = VTX_W'({rd_data, lo_q});
        st_d  = ST_EMIT;
      end
      ST_EMIT: begin
        if (xfer) begin
          if (last) begin
            done_d = 1'b1;
            st_d   = ST_IDLE;
          end else begin
            rem_d = rem_q - CNT_W'(1);
            if (idx_q) begin
              ptr_step = 1'b1;
              st_d     = ST_RDLO;
            end else begin
              num_d = num_q + VTX_W'(1);
            end
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      rem_q  <= '0;
      num_q  <= '0;
      lo_q   <= '0;
      idx_q  <= 1'b0;
      wide_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      rem_q  <= rem_d;
      num_q  <= num_d;
      lo_q   <= lo_d;
      idx_q  <= idx_d;
      wide_q <= wide_d;
      done_q <= done_d;
    end
  end

  assign vtx_valid = (st_q == ST_EMIT);
  assign vtx_num   = num_q;
  assign done      = done_q;
  assign busy      = (st_q != ST_IDLE);
endmodule

// File: rtl/vis_sequencer.sv
`timescale 1ns/1ps
module vis_sequencer
  import vis_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int VTX_W  = 32,
  parameter int CNT_W  = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_wr_en,
  input  logic [REG_AW-1:0]  cfg_wr_addr,
  input  logic [31:0]        cfg_wr_data,
  output logic               mem_rd_en,
  output logic [ADDR_W-1:0]  mem_rd_addr,
  input  logic [7:0]         mem_rd_data,
  output logic               vtx_valid,
  input  logic               vtx_ready,
  output logic [VTX_W-1:0]   vtx_num,
  output logic               draw_done,
  output logic               busy
);
  logic [BASE_W-1:0] base_q;
  logic [31:0]       desc_q;
  logic [CNT_W-1:0]  count_q;
  logic [VTX_W-1:0]  first_q;
  logic              go_lin, go_idx;
  logic              ptr_load, ptr_step, hi_sel, wide_q;

  vis_cfg_regs #(.VTX_W(VTX_W), .CNT_W(CNT_W)) cfg_i (
    .clk(clk), .rst_n(rst_n),
    .wr_en(cfg_wr_en), .wr_addr(cfg_wr_addr), .wr_data(cfg_wr_data),
    .base_q(base_q), .desc_q(desc_q), .count_q(count_q), .first_q(first_q),
    .go_lin(go_lin), .go_idx(go_idx)
  );

  vis_addr_gen #(.ADDR_W(ADDR_W)) agen_i (
    .clk(clk), .rst_n(rst_n),
    .load(ptr_load), .step(ptr_step), .wide(wide_q), .hi_sel(hi_sel),
    .base(base_q), .offset(desc_q[DESC_OFF_W-1:0]),
    .rd_addr(mem_rd_addr)
  );

  vis_seq_ctrl #(.VTX_W(VTX_W), .CNT_W(CNT_W)) ctrl_i (
    .clk(clk), .rst_n(rst_n),
    .go_lin(go_lin), .go_idx(go_idx),
    .cfg_count(count_q), .cfg_first(first_q), .cfg_wide(desc_q[31]),
    .rd_data(mem_rd_data), .vtx_ready(vtx_ready),
    .ptr_load(ptr_load), .ptr_step(ptr_step), .hi_sel(hi_sel), .wide_q(wide_q),
    .rd_en(mem_rd_en), .vtx_valid(vtx_valid), .vtx_num(vtx_num),
    .done(draw_done), .busy(busy)
  );
endmodule

// File: rtl/vis_sequencer_chk.sv
`timescale 1ns/1ps
module vis_sequencer_chk
  import vis_pkg::*;
#(
  parameter int VTX_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_wr_en,
  input logic [REG_AW-1:0] cfg_wr_addr,
  input logic              mem_rd_en,
  input logic              vtx_valid,
  input logic              vtx_ready,
  input logic [VTX_W-1:0]  vtx_num,
  input logic              draw_done,
  input logic              busy
);
  logic trig_wr;
  assign trig_wr = cfg_wr_en && ((cfg_wr_addr == ADR_GO_LIN) || (cfg_wr_addr == ADR_GO_IDX));

  assert_hold_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (vtx_valid && !vtx_ready) |=> (vtx_valid && $stable(vtx_num)));

  assert_valid_in_draw_R6: assert property (@(posedge clk) disable iff (!rst_n)
    vtx_valid |-> busy);

  assert_done_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    draw_done |-> !busy);

  assert_end_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> draw_done);

  assert_start_by_trigger_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(trig_wr));

  assert_retrigger_dropped_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && trig_wr && !(vtx_valid && vtx_ready)) |=> busy);

  assert_read_in_draw_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |-> busy);
endmodule

bind vis_sequencer vis_sequencer_chk #(.VTX_W(VTX_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_addr(cfg_wr_addr),
  .mem_rd_en(mem_rd_en), .vtx_valid(vtx_valid), .vtx_ready(vtx_ready),
  .vtx_num(vtx_num), .draw_done(draw_done), .busy(busy)
);

// File: tb/vis_sequencer_tb.sv
`timescale 1ns/1ps
module vis_sequencer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr_en = 1'b0;
  logic [9:0]  cfg_wr_addr = '0;
  logic [31:0] cfg_wr_data = '0;
  logic        mem_rd_en;
  logic [31:0] mem_rd_addr;
  logic [7:0]  mem_rd_data = '0;
  logic        vtx_valid;
  logic        vtx_ready = 1'b0;
  logic [31:0] vtx_num;
  logic        draw_done;
  logic        busy;

  always #2 clk = ~clk;

  vis_sequencer dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_addr(cfg_wr_addr),
    .cfg_wr_data(cfg_wr_data), .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
    .mem_rd_data(mem_rd_data), .vtx_valid(vtx_valid), .vtx_ready(vtx_ready),
    .vtx_num(vtx_num), .draw_done(draw_done), .busy(busy)
  );

  function automatic logic [7:0] mem_byte(input logic [31:0] a);
    return a[7:0] ^ {a[10:8], 5'b0} ^ 8'h5A;
  endfunction

  always @(posedge clk) if (mem_rd_en) mem_rd_data <= mem_byte(mem_rd_addr);

  int n_chk = 0, n_fail = 0, emitted = 0, rdy_mode = 0;
  logic [28:0] m_base = '0;
  logic [31:0] m_desc = '0, m_count = '0, m_first = '0, last_num = '0;
  logic [31:0] exp_q[$];
  bit m_active = 0, m_idx = 0, exp_done = 0, mon_on = 0;
  string m_tag = "R2", done_tag = "R6";

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  always begin
    @(posedge clk); #1;
    case (rdy_mode)
      0: vtx_ready = 1'b1;
      1: vtx_ready = $urandom_range(0, 1) == 1;
      default: vtx_ready = 1'b0;
    endcase
  end

  // Behavioural reference: queue of expected numbers, compared every clock
  always @(negedge clk) begin
    if (rst_n && mon_on) begin
      bit was_active, nxt_done;
      logic [31:0] e;
      was_active = m_active;
      nxt_done = 0;
      chk(draw_done == exp_done, done_tag, "draw_done", 32'(draw_done), 32'(exp_done));
      chk(busy == m_active, "R6", "busy", 32'(busy), 32'(m_active));
      if (mem_rd_en) chk(m_active && m_idx, "R10", "read outside indexed draw", 1, 0);
      if (vtx_valid) begin
        if (exp_q.size() == 0) chk(0, "R5", "valid with nothing due", 1, 0);
        else if (vtx_ready) begin
          e = exp_q.pop_front();
          chk(vtx_num == e, m_tag, "vertex number", vtx_num, e);
          emitted++;
          last_num = vtx_num;
          if (exp_q.size() == 0) begin nxt_done = 1; done_tag = "R6"; m_active = 0; end
        end
      end
      if (cfg_wr_en) begin
        case (cfg_wr_addr)
          10'h200: m_base = cfg_wr_data[28:0];
          10'h227: m_desc = cfg_wr_data;
          10'h228: m_count = cfg_wr_data;
          10'h22A: m_first = cfg_wr_data;
          10'h22E, 10'h22F: if (!was_active) begin
            m_idx = (cfg_wr_addr == 10'h22F);
            m_tag = !m_idx ? "R2" : (m_desc[31] ? "R4" : "R3");
            for (int i = 0; i < int'(m_count); i++) begin
              logic [31:0] a;
              if (!m_idx) exp_q.push_back(m_first + 32'(i));
              else if (m_desc[31]) begin
                a = {m_base, 3'b000} + {1'b0, m_desc[30:0]} + 32'(2 * i);
                exp_q.push_back({16'h0, mem_byte(a + 1), mem_byte(a)});
              end else begin
                a = {m_base, 3'b000} + {1'b0, m_desc[30:0]} + 32'(i);
                exp_q.push_back({24'h0, mem_byte(a)});
              end
            end
            if (m_count == 0) begin nxt_done = 1; done_tag = "R7"; end
            else m_active = 1;
          end
          default: ;
        endcase
      end
      exp_done = nxt_done;
    end
  end

  task automatic wr(input logic [9:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    cfg_wr_en = 1'b1; cfg_wr_addr = a; cfg_wr_data = d;
    @(posedge clk); #1;
    cfg_wr_en = 1'b0;
  endtask

  task automatic wait_idle();
    do @(posedge clk); while (m_active || exp_done);
    repeat (3) @(posedge clk);
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL R6 watchdog actual=hung expected=idle");
    report();
  end

  initial begin
    repeat (3) @(posedge clk); #1;
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy, "R9", "busy after reset", 32'(busy), 0);
    chk(!vtx_valid, "R9", "valid after reset", 32'(vtx_valid), 0);
    chk(!draw_done, "R9", "done after reset", 32'(draw_done), 0);
    chk(!mem_rd_en, "R9", "read after reset", 32'(mem_rd_en), 0);
    mon_on = 1;

    // R2 linear, always ready
    rdy_mode = 0;
    wr(10'h228, 5); wr(10'h22A, 100); wr(10'h22E, 0); wait_idle();
    // R2 wrap-around with stalls (R5)
    rdy_mode = 1;
    wr(10'h228, 4); wr(10'h22A, 32'hFFFF_FFFE); wr(10'h22E, 0); wait_idle();
    // R3 one-byte indices, offset register set but ignored
    wr(10'h200, 32'h40); wr(10'h227, 32'h0000_0003); wr(10'h228, 6);
    wr(10'h22A, 999); wr(10'h22F, 0); wait_idle();
    // R4 two-byte indices, stalled consumer
    wr(10'h200, 32'h100); wr(10'h227, 32'h8000_0005); wr(10'h228, 5);
    wr(10'h22F, 0); wait_idle();
    rdy_mode = 0;
    wr(10'h22F, 0); wait_idle();
    // R7 zero count, both modes
    wr(10'h228, 0); wr(10'h22E, 0); wait_idle();
    wr(10'h22F, 0); wait_idle();
    // R8 retrigger while busy; R1 snapshot under mid-draw config change
    rdy_mode = 2;
    wr(10'h228, 8); wr(10'h22A, 50); wr(10'h22E, 0);
    emitted = 0;
    repeat (4) @(posedge clk);
    wr(10'h22F, 0);
    wr(10'h22A, 7);
    wr(10'h22E, 0);
    rdy_mode = 1;
    wait_idle();
    chk(emitted == 8, "R8", "numbers in draw with dropped triggers", 32'(emitted), 8);
    chk(last_num == 57, "R1", "last number uses snapshot", last_num, 57);
    rdy_mode = 0;
    wr(10'h228, 2); wr(10'h22E, 0); wait_idle();
    chk(last_num == 8, "R1", "new offset used by next draw", last_num, 8);
    report();
  end
endmodule